// File: doc/BRIEF.md
# DMA Channel Transfer Counter with End Flag

This block keeps the transfer count and the end-of-transfer flag for one DMA channel. Software loads a 24-bit count through a small two-register port. The transfer engine pulses `unit_done` once for every completed transfer unit. A 16-byte transfer is one unit, the same as any other transfer size. While the channel is enabled and its end flag is clear, each pulse lowers the count by one, and reading the count returns the number of units still to go. A programmed count of zero stands for 2^24 units.

When an accepted pulse takes the count from 1 to 0, the channel ends. The end flag rises, later pulses are ignored, and `irq` goes high if the interrupt enable is set. Software clears the flag with a two-step handshake. It first reads the control word while the flag is 1, then writes 0 to the flag bit. A write of 0 that no such read preceded leaves the flag set. A write of 1 never changes it.

A three-state machine tracks the handshake:

- `ST_COUNT`: flag clear; accepted pulses decrement the count.
- `ST_END`: flag set; software has not yet seen it.
- `ST_END_SEEN`: flag set and read back as 1.

Transitions:

- `ST_COUNT` to `ST_END` (last unit): an accepted pulse while the count is 1.
- `ST_END` to `ST_END_SEEN` (flag observed): a control-word read.
- `ST_END_SEEN` to `ST_COUNT` (flag cleared): a control-word write with the flag bit 0.
- Every other event keeps the current state.

Top module: `dmacnt_unit`

## Requirements
- R1: Register select 0 is the count register. Bits 23:0 hold the count. Bits 31:24 read as 0, and written values there are discarded. For example, writing 0xFF000005 reads back as 0x00000005.
- R2: A `unit_done` pulse lowers the count by exactly one when the enable bit is 1 and the end flag is 0. With the enable bit at 0 the pulse leaves the count unchanged.
- R3: After a programmed count N (N >= 1), the end flag becomes 1 on the Nth accepted pulse. Until then, reads of the count return the units remaining.
- R4: A programmed count of 0 means 2^24 units. The first accepted pulse gives 0x00FFFFFF and does not set the end flag.
- R5: While the end flag is 1, `unit_done` pulses are ignored and the count stays where it is.
- R6: Register select 1 is the control word. Bit 0 is the channel enable, bit 1 is the end flag and bit 2 is the interrupt enable. All other bits read as 0.
- R7: The end flag clears only on a control write with bit 1 = 0 that follows a control read which returned bit 1 = 1. A 0-write with no such read leaves the flag set, and writing 1 to bit 1 has no effect.
- R8: `irq` equals the end flag AND the interrupt enable, and it stays high until the flag is cleared.
- R9: After reset, the count, the enable bits and the end flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 count, 1 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe, used for the flag handshake |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| unit_done | input | 1 | One-cycle pulse per completed transfer unit |
| irq | output | 1 | Transfer-end interrupt |

## Verification
The count path is driven with pulses while the channel is disabled, with partial runs from a mid-range count, and with runs that reach the end. Together these separate gating errors from off-by-one errors in the final decrement. Starting counts of 1 and 0 isolate the terminal-count test from the wraparound that stands for 2^24. The clear handshake is exercised in three ways: a 0-write before any read, a 1-write after a read, and a 0-write after a read. Only the last of these may drop `irq` and the flag. Writes carrying set upper bits in both registers show that unused bits are discarded.

// File: rtl/dmacnt_pkg.sv
package dmacnt_pkg;
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_END_BIT = 1;
    localparam int CTL_IE_BIT  = 2;
    localparam int CTL_USED    = 3;

    typedef enum logic [1:0] {
        ST_COUNT    = 2'd0,
        ST_END      = 2'd1,
        ST_END_SEEN = 2'd2
    } end_state_t;
endpackage

// File: rtl/dmacnt_regif.sv
module dmacnt_regif
    import dmacnt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              end_flag,
    output logic              wr_cnt,
    output logic              wr_ctl,
    output logic              rd_ctl,
    output logic              ctl_en,
    output logic              ctl_ie,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int PAD_W = DATA_W - CNT_W;
    localparam int CPAD  = DATA_W - CTL_USED;

    assign wr_cnt = reg_wr & ~reg_sel;
    assign wr_ctl = reg_wr &  reg_sel;
    assign rd_ctl = reg_rd &  reg_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en <= 1'b0;
            ctl_ie <= 1'b0;
        end else if (wr_ctl) begin
            ctl_en <= reg_wdata[CTL_EN_BIT];
            ctl_ie <= reg_wdata[CTL_IE_BIT];
        end
    end

    always_comb begin
        if (reg_sel) begin
            reg_rdata = {{CPAD{1'b0}}, ctl_ie, end_flag, ctl_en};
        end else begin
            reg_rdata = {{PAD_W{1'b0}}, cnt};
        end
    end

    // R6: control bits follow the last control write
    p_ctl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (ctl_en == $past(reg_wdata[CTL_EN_BIT]) &&
                    ctl_ie == $past(reg_wdata[CTL_IE_BIT])));
endmodule

// File: rtl/dmacnt_counter.sv
module dmacnt_counter #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    output logic [CNT_W-1:0]  cnt,
    output logic              at_one
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val[CNT_W-1:0];
        end else if (step) begin
            cnt <= cnt - ONE;
        end
    end

    assign at_one = (cnt == ONE);

    // R2: an accepted step lowers the count by one (0 wraps to all ones, R4)
    p_step_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt + ONE == $past(cnt)));

    // R1: a load keeps only the low count bits
    p_load_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val[CNT_W-1:0])));
endmodule

// File: rtl/dmacnt_endfsm.sv
module dmacnt_endfsm
    import dmacnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic unit_done,
    input  logic ctl_en,
    input  logic ctl_ie,
    input  logic at_one,
    input  logic rd_ctl,
    input  logic wr_ctl,
    input  logic wr_end_bit,
    output logic step,
    output logic end_flag,
    output logic irq
);
    end_state_t state, state_nx;

    assign step = unit_done & ctl_en & (state == ST_COUNT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COUNT:    if (step && at_one)            state_nx = ST_END;
            ST_END:      if (rd_ctl)                    state_nx = ST_END_SEEN;
            ST_END_SEEN: if (wr_ctl && !wr_end_bit)     state_nx = ST_COUNT;
            default:                                    state_nx = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_COUNT;
        else        state <= state_nx;
    end

    always_comb begin
        end_flag = (state == ST_END) || (state == ST_END_SEEN);
        irq      = end_flag & ctl_ie;
    end

    // R7: a flag never observed by a read cannot be cleared
    p_no_blind_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END) |=> end_flag);

    // R7: writing 1 to the flag bit keeps it set
    p_one_write_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_flag && wr_ctl && wr_end_bit) |=> end_flag);

    // R3: the last accepted unit raises the flag
    p_last_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_one) |=> end_flag);
endmodule

// File: rtl/dmacnt_unit.sv
module dmacnt_unit
    import dmacnt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              unit_done,
    output logic              irq
);
    logic [CNT_W-1:0] cnt;
    logic wr_cnt, wr_ctl, rd_ctl, ctl_en, ctl_ie;
    logic step, at_one, end_flag;

    dmacnt_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .cnt(cnt), .end_flag(end_flag),
        .wr_cnt(wr_cnt), .wr_ctl(wr_ctl), .rd_ctl(rd_ctl),
        .ctl_en(ctl_en), .ctl_ie(ctl_ie), .reg_rdata(reg_rdata)
    );

    dmacnt_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(reg_wdata),
        .step(step), .cnt(cnt), .at_one(at_one)
    );

    dmacnt_endfsm u_fsm (
        .clk(clk), .rst_n(rst_n), .unit_done(unit_done), .ctl_en(ctl_en),
        .ctl_ie(ctl_ie), .at_one(at_one), .rd_ctl(rd_ctl), .wr_ctl(wr_ctl),
        .wr_end_bit(reg_wdata[CTL_END_BIT]), .step(step),
        .end_flag(end_flag), .irq(irq)
    );

    // R5: once ended, the count holds unless software reloads it
    p_hold_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_flag && !wr_cnt) |=> $stable(cnt));

    // R8: interrupt implies the enable is set
    p_irq_needs_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_ie);

    // R1: upper bits of the count register read as zero
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (reg_rdata[DATA_W-1:CNT_W] == '0));
endmodule

// File: tb/tb_dmacnt_unit.sv
module tb_dmacnt_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        unit_done = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dmacnt_unit dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .unit_done(unit_done), .irq(irq)
    );

    // monitor: compares expected and observed items in order
    initial begin
        forever begin
            @(posedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [31:0] e, a;
                string t;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input logic sel, input logic [31:0] e, input string t);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        #1 act_q.push_back(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic irq_chk(input logic e, input string t);
        @(negedge clk);
        exp_q.push_back({31'b0, e}); tag_q.push_back(t);
        act_q.push_back({31'b0, irq});
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            unit_done = 1'b1;
            @(negedge clk);
            unit_done = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(0, 32'h0, "R9 count after reset");
        rd_chk(1, 32'h0, "R9 control after reset");
        irq_chk(0, "R9 irq after reset");

        wr(0, 32'hFF00_0005);
        rd_chk(0, 32'h0000_0005, "R1 upper count bits dropped");
        pulses(2);
        rd_chk(0, 32'h0000_0005, "R2 pulses ignored while disabled");

        wr(1, 32'h0000_0005);
        pulses(2);
        rd_chk(0, 32'h0000_0003, "R2 two accepted pulses");
        rd_chk(1, 32'h0000_0005, "R3 flag clear before end");
        pulses(2);
        rd_chk(0, 32'h0000_0001, "R3 remaining count");
        irq_chk(0, "R3 not ended at one");
        pulses(1);
        rd_chk(0, 32'h0000_0000, "R3 count exhausted");
        irq_chk(1, "R8 irq on end");
        wr(1, 32'h0000_0005);
        irq_chk(1, "R7 zero-write before read keeps flag");
        pulses(3);
        rd_chk(0, 32'h0000_0000, "R5 pulses ignored after end");
        rd_chk(1, 32'h0000_0007, "R6 control shows flag");
        wr(1, 32'h0000_0007);
        irq_chk(1, "R7 one-write keeps flag");
        wr(1, 32'h0000_0005);
        irq_chk(0, "R7 read-then-zero clears flag");
        rd_chk(1, 32'h0000_0005, "R8 flag and irq cleared");

        wr(0, 32'h0000_0000);
        pulses(1);
        rd_chk(0, 32'h00FF_FFFF, "R4 zero count wraps");
        irq_chk(0, "R4 no end after wrap");

        wr(0, 32'h00FF_FFFF);
        rd_chk(0, 32'h00FF_FFFF, "R1 full count");

        wr(1, 32'h0000_0001);
        wr(0, 32'h0000_0001);
        pulses(1);
        irq_chk(0, "R8 no irq with ie off");
        rd_chk(1, 32'h0000_0003, "R3 single-unit end");
        wr(1, 32'hFFFF_FFF9);
        rd_chk(1, 32'h0000_0001, "R6 unused control bits read zero");

        repeat (3) @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule